// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge lets a bus master reach single bits of a target memory region through a much larger alias window. Every 32-bit aligned word in a 32 MiB alias window stands for one bit of a 1 MiB target region. Each target byte is covered by eight consecutive alias words.

An alias read fetches the target byte, halfword or word that holds the selected bit, and returns that bit as 0 or 1. An alias write performs a locked read-modify-write. The bridge reads the unit of the requested size, forces the selected bit to bit 0 of the write data, and writes the unit back at the same address and size. No other transaction runs on the master port in between.

The bridge takes one alias transaction at a time. On the slave side it has a request/ready port. On the memory side it has a single-outstanding master port with a ready pulse. Both the alias base and the target base are parameters.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is held and on the first clock after it is released, `s_ready` and `m_req` are both 0.
- R2: With alias offset `off` = (`s_addr` - alias base) bits [24:0], the master address is the target base ORed with `off >> 5`. For size 1 (halfword) bit 0 is cleared, and for size 2 (word) bits [1:0] are cleared. `m_size` repeats `s_size`.
- R3: For size 0 (byte), the bit index is `off[4:2]` within the fetched byte.
- R4: For size 1 (halfword), the bit index is `off[5:2]`. The target is little-endian, so bit n lies in byte n/8 of the unit at position n mod 8.
- R5: For size 2 (word), the bit index is `off[6:2]`, with the same little-endian placement as R4.
- R6: A read response carries the selected bit in `s_rdata[0]`. All other `s_rdata` bits are 0.
- R7: A write with `s_wdata[0]`=1 sets the selected target bit and leaves every other bit of the target unchanged.
- R8: A write with `s_wdata[0]`=0 clears the selected bit even when other `s_wdata` bits are 1. Every other bit is left unchanged.
- R9: A write issues one master read and then exactly one master write to the same address and size. The write request follows the read's ready pulse on the very next cycle. A read issues no master write.
- R10: `s_ready` is a single-cycle pulse. For a read it comes one cycle after the master read's ready. For a write it comes one cycle after the master write's ready. With a memory that answers one cycle after request, this puts `s_ready` 3 cycles after the request is accepted for a read and 5 cycles after for a write.
- R11: A write response returns `s_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Alias request, held until `s_ready` |
| s_addr | input | 32 | Alias byte address |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word |
| s_we | input | 1 | 1 write, 0 read |
| s_wdata | input | 32 | Write data; bit 0 is the new bit value |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result, 0 or 1 |
| m_req | output | 1 | Memory request, held until `m_ready` |
| m_addr | output | 32 | Target byte address |
| m_size | output | 2 | Target access size |
| m_we | output | 1 | Memory write enable |
| m_wdata | output | 32 | Unit write data, right-aligned |
| m_ready | input | 1 | Memory completion pulse |
| m_rdata | input | 32 | Unit read data, right-aligned, valid with `m_ready` |

## Verification
A wrong bit index or a wrong alignment shows up within one transaction. It appears as a wrong 0/1 on `s_rdata`, or as a neighbouring bit that changed in the target memory. The bench catches it when it compares the whole unit after every write. A control state that loses track appears as an `s_ready` pulse in the wrong cycle, or as a missing or extra master write. The bench checks `s_ready` against the expected value on every cycle of every transaction, and counts the master transactions, so such a fault is reported within a few cycles of the request.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} bb_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_MODIFY_WRITE, ST_RESPOND} bb_state_e;

  localparam int OFF_W = 25;
  localparam int IDX_W = 5;

  // Target unit address: base ORed with offset / 32, then aligned to the size.
  function automatic logic [31:0] bb_target(input logic [31:0] tbase,
                                            input logic [OFF_W-1:0] off,
                                            input logic [1:0] size);
    logic [31:0] a;
    a = tbase | (32'(off) >> 5);
    case (size)
      SZ_BYTE: ;
      SZ_HALF: a[0] = 1'b0;
      default: a[1:0] = 2'b00;
    endcase
    return a;
  endfunction

  // Bit number inside the fetched unit.
  function automatic logic [IDX_W-1:0] bb_bit_idx(input logic [OFF_W-1:0] off,
                                                  input logic [1:0] size);
    case (size)
      SZ_BYTE: return {2'b00, off[4:2]};
      SZ_HALF: return {1'b0, off[5:2]};
      default: return off[6:2];
    endcase
  endfunction

  function automatic logic [31:0] bb_unit_mask(input logic [1:0] size);
    case (size)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bb_xlate.sv
module bb_xlate
  import bb_pkg::*;
#(
  parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
  parameter logic [31:0] TARGET_BASE = 32'h2000_0000
) (
  input  logic [31:0]      alias_addr,
  input  logic [1:0]       size,
  output logic [31:0]      tgt_addr,
  output logic [IDX_W-1:0] bit_idx
);
  logic [31:0]      rel;
  logic [OFF_W-1:0] off;

  assign rel      = alias_addr - ALIAS_BASE;
  assign off      = rel[OFF_W-1:0];
  assign tgt_addr = bb_target(TARGET_BASE, off, size);
  assign bit_idx  = bb_bit_idx(off, size);
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
  import bb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_req,
  input  logic             s_we,
  input  logic             new_val,
  input  logic [1:0]       s_size,
  input  logic [31:0]      tgt_addr,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             m_ready,
  output bb_state_e        state,
  output logic             m_req,
  output logic             m_we,
  output logic [31:0]      m_addr,
  output logic [1:0]       m_size,
  output logic             s_ready,
  output logic             cap_rd,
  output logic             we_q,
  output logic             val_q,
  output logic [IDX_W-1:0] idx_q
);
  logic [31:0] addr_q;
  logic [1:0]  size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      size_q <= '0;
      idx_q  <= '0;
      we_q   <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (s_req) begin
          addr_q <= tgt_addr;
          size_q <= s_size;
          idx_q  <= bit_idx;
          we_q   <= s_we;
          val_q  <= new_val;
          state  <= ST_READ;
        end
        ST_READ:         if (m_ready) state <= we_q ? ST_MODIFY_WRITE : ST_RESPOND;
        ST_MODIFY_WRITE: if (m_ready) state <= ST_RESPOND;
        default:         state <= ST_IDLE;
      endcase
    end
  end

  assign m_req   = (state == ST_READ) || (state == ST_MODIFY_WRITE);
  assign m_we    = (state == ST_MODIFY_WRITE);
  assign m_addr  = addr_q;
  assign m_size  = size_q;
  assign s_ready = (state == ST_RESPOND);
  assign cap_rd  = (state == ST_READ) && m_ready;

  // R9: write-back request directly after the read's ready pulse
  p_rmw_back_to_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_rd && we_q) |=> (m_req && m_we));
  // R9: address and size hold across the read-to-write switch
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_we) |-> ($stable(m_addr) && $stable(m_size)));
  // R10: completion is a single-cycle pulse
  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);
  // R10: completion only after a memory ready
  p_ready_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> $past(m_ready));
endmodule

// File: rtl/bb_rmw.sv
module bb_rmw
  import bb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_rd,
  input  logic [31:0]      m_rdata,
  input  logic [1:0]       size,
  input  logic [IDX_W-1:0] idx,
  input  logic             val,
  output logic [31:0]      wr_data,
  output logic             rd_bit
);
  logic [31:0] unit_q;
  logic [31:0] sel;

  always_ff @(posedge clk) begin
    if (!rst_n)      unit_q <= '0;
    else if (cap_rd) unit_q <= m_rdata & bb_unit_mask(size);
  end

  assign sel     = 32'd1 << idx;
  assign wr_data = val ? (unit_q | sel) : (unit_q & ~sel);
  assign rd_bit  = |(unit_q & sel);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] ALIAS_BASE  = 32'h2200_0000,
  parameter logic [31:0] TARGET_BASE = 32'h2000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_req,
  input  logic [31:0] s_addr,
  input  logic [1:0]  s_size,
  input  logic        s_we,
  input  logic [31:0] s_wdata,
  output logic        s_ready,
  output logic [31:0] s_rdata,
  output logic        m_req,
  output logic [31:0] m_addr,
  output logic [1:0]  m_size,
  output logic        m_we,
  output logic [31:0] m_wdata,
  input  logic        m_ready,
  input  logic [31:0] m_rdata
);
  logic [31:0]      tgt_addr;
  logic [IDX_W-1:0] bit_idx;
  logic [IDX_W-1:0] idx_q;
  bb_state_e        state;
  logic             cap_rd, we_q, val_q, rd_bit;

  bb_xlate #(.ALIAS_BASE(ALIAS_BASE), .TARGET_BASE(TARGET_BASE)) xlate_i (
    .alias_addr(s_addr), .size(s_size), .tgt_addr(tgt_addr), .bit_idx(bit_idx));

  bb_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .new_val(s_wdata[0]),
    .s_size(s_size), .tgt_addr(tgt_addr), .bit_idx(bit_idx), .m_ready(m_ready),
    .state(state), .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
    .s_ready(s_ready), .cap_rd(cap_rd), .we_q(we_q), .val_q(val_q), .idx_q(idx_q));

  bb_rmw rmw_i (
    .clk(clk), .rst_n(rst_n), .cap_rd(cap_rd), .m_rdata(m_rdata), .size(m_size),
    .idx(idx_q), .val(val_q), .wr_data(m_wdata), .rd_bit(rd_bit));

  assign s_rdata = {31'd0, s_ready & ~we_q & rd_bit};

  // R6: read response is a single bit
  p_bool_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (s_rdata[31:1] == 31'd0));
  // R7: write-back differs from the fetched unit in at most one bit
  p_one_bit_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req && m_we) |-> ($countones(m_wdata ^ ($past(m_rdata) & bb_unit_mask(m_size))) <= 1));
  // R11: writes answer with zero
  p_write_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && state == ST_RESPOND && we_q) |-> (s_rdata == 32'd0));
endmodule

// File: tb/bitband_bridge_tb_top.sv
`timescale 1ns/1ps
module bitband_bridge_tb_top;
  localparam logic [31:0] AB = 32'h2200_0000;
  localparam logic [31:0] TB = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_req = 1'b0, s_we = 1'b0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  logic [1:0] s_size = '0;
  logic s_ready, m_req, m_we;
  logic [31:0] s_rdata, m_addr, m_wdata;
  logic [1:0] m_size;
  logic m_ready = 1'b0;
  logic [31:0] m_rdata = '0;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0, cyc = 0;
  int last_rd_cyc = 0, last_wr_cyc = 0;
  logic [31:0] last_waddr = '0, last_raddr = '0;
  logic [1:0] last_wsize = '0;
  logic [7:0] dmem [int unsigned];
  logic [7:0] rmem [int unsigned];
  int unsigned lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  bitband_bridge #(.ALIAS_BASE(AB), .TARGET_BASE(TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_addr(s_addr), .s_size(s_size),
    .s_we(s_we), .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
    .m_req(m_req), .m_addr(m_addr), .m_size(m_size), .m_we(m_we),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata));

  function automatic logic [7:0] pat(input int unsigned a);
    return 8'((a * 37) ^ (a >> 8) ^ 32'h5A);
  endfunction
  function automatic logic [7:0] dget(input int unsigned a);
    return dmem.exists(a) ? dmem[a] : pat(a);
  endfunction
  function automatic logic [7:0] rget(input int unsigned a);
    return rmem.exists(a) ? rmem[a] : pat(a);
  endfunction

  // Behavioural memory: answers one cycle after a request.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) m_ready <= 1'b0;
    else if (m_req && !m_ready) begin
      int nb;
      logic [31:0] v;
      nb = (m_size == 2'd0) ? 1 : (m_size == 2'd1) ? 2 : 4;
      v = '0;
      if (m_we) begin
        for (int i = 0; i < nb; i++) dmem[m_addr + i] = m_wdata[8*i +: 8];
        wr_cnt++; last_waddr = m_addr; last_wsize = m_size; last_wr_cyc = cyc;
      end else begin
        for (int i = 0; i < nb; i++) v[8*i +: 8] = dget(m_addr + i);
        m_rdata <= v;
        rd_cnt++; last_raddr = m_addr; last_rd_cyc = cyc;
      end
      m_ready <= 1'b1;
    end else m_ready <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic txn(input int unsigned off, input int sz, input bit we,
                     input logic [31:0] wd, input string req);
    int unsigned tbyte, unit, n, baddr;
    int lat, rd0, wr0;
    bit exp_bit, seen;
    off = off % 32'h0200_0000;
    tbyte = TB + off / 32;
    n = (off / 4) % ((sz == 0) ? 8 : (sz == 1) ? 16 : 32);
    unit = (sz == 0) ? tbyte : (sz == 1) ? tbyte - tbyte % 2 : tbyte - tbyte % 4;
    baddr = unit + n / 8;
    exp_bit = rget(baddr)[n % 8];
    if (we) begin
      logic [7:0] b;
      b = rget(baddr);
      b[n % 8] = wd[0];
      rmem[baddr] = b;
    end
    lat = we ? 5 : 3;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    s_req = 1'b1; s_addr = AB + off; s_size = 2'(sz); s_we = we; s_wdata = wd;
    seen = 1'b0;
    for (int k = 1; k <= 8 && !seen; k++) begin
      @(negedge clk);
      if (s_ready !== (k == lat)) begin
        chk(1'b0, "R10", "s_ready timing", 32'(s_ready), 32'(k == lat));
        seen = 1'b1;
      end else if (k == lat) begin
        chk(1'b1, "R10", "s_ready timing", 32'(s_ready), 32'd1);
        seen = 1'b1;
        if (we) chk(s_rdata == 32'd0, "R11", "write response", s_rdata, 32'd0);
        else chk(s_rdata == 32'(exp_bit), req, "read bit", s_rdata, 32'(exp_bit));
      end
    end
    s_req = 1'b0;
    while (s_ready) @(negedge clk);
    chk(rd_cnt - rd0 == 1, "R9", "master reads", 32'(rd_cnt - rd0), 32'd1);
    chk(last_raddr == unit, "R2", "target address", last_raddr, unit);
    if (we) begin
      chk(wr_cnt - wr0 == 1, "R9", "master writes", 32'(wr_cnt - wr0), 32'd1);
      chk(last_waddr == unit && last_wsize == 2'(sz), "R9", "write-back addr",
          last_waddr, unit);
      chk(last_wr_cyc - last_rd_cyc == 2, "R9", "write-back gap",
          32'(last_wr_cyc - last_rd_cyc), 32'd2);
      for (int i = 0; i < 4; i++)
        chk(dget(unit + i) == rget(unit + i), req, "memory byte",
            32'(dget(unit + i)), 32'(rget(unit + i)));
    end else
      chk(wr_cnt == wr0, "R9", "no write on read", 32'(wr_cnt - wr0), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(s_ready == 1'b0 && m_req == 1'b0, "R1", "during reset",
        {s_ready, m_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b0 && m_req == 1'b0, "R1", "after reset",
        {s_ready, m_req}, 32'd0);
    // directed reads of each size, including the last alias word
    txn(32'h0000_001C, 0, 1'b0, 0, "R3");
    txn(32'h0000_0008, 0, 1'b0, 0, "R3");
    txn(32'h0000_0034, 1, 1'b0, 0, "R4");
    txn(32'h0000_007C, 2, 1'b0, 0, "R5");
    txn(32'h01FF_FFFC, 2, 1'b0, 0, "R5");
    // set, clear, and clear with upper data bits set
    txn(32'h0000_0104, 0, 1'b1, 32'h1, "R7");
    txn(32'h0000_0104, 0, 1'b0, 32'h0, "R3");
    txn(32'h0000_0238, 1, 1'b1, 32'h1, "R7");
    txn(32'h0000_0238, 1, 1'b0, 32'hFFFF_FFFE, "R8");
    txn(32'h0000_047C, 2, 1'b1, 32'h1, "R7");
    txn(32'h0000_047C, 2, 1'b0, 32'h8000_0000, "R8");
    txn(32'h0000_047C, 2, 1'b0, 0, "R5");
    txn(32'h01FF_FFFC, 0, 1'b0, 32'hFFFF_FFF0, "R8");
    for (int t = 0; t < 80; t++) begin
      int unsigned o;
      lcg = lcg * 1103515245 + 12345;
      o = (lcg >> 3) % 32'h0000_2000;
      txn(o & ~32'h3, int'((lcg >> 20) % 3), lcg[27], {lcg[31:1], lcg[24]},
          lcg[27] ? (lcg[24] ? "R7" : "R8") : "R6");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule